// File: doc/BRIEF.md
# Unicast Receive Address Filter

This block keeps a small table of unicast station addresses and checks the destination address of every incoming frame against all entries that are marked valid. A frame parser upstream presents the 48-bit destination address together with a one-cycle strobe. One clock later the block reports whether any valid entry matched and, if so, which one. When several entries hold the same address, the lowest index wins.

Software fills the table through a plain 32-bit register port. Each entry has a low word and a high word. The address bytes are stored with the first byte on the wire in the least significant position. The block owns the valid flag. It sets the flag when the high word is written and the complete 48-bit address, taken from the stored low word and the incoming high half, is nonzero. A separate initialise pulse loads the station address into entry 0 and clears every other entry.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every entry reads back as zero and is invalid, and `match_valid` is low.
- R2: `reg_addr[0]` selects the half: 0 is the low word and 1 is the high word. `reg_addr[IDX_W:1]` selects the entry. The low word holds address byte 0 in bits 7:0, byte 1 in bits 15:8, byte 2 in bits 23:16 and byte 3 in bits 31:24.
- R3: The high word holds address byte 4 in bits 7:0 and byte 5 in bits 15:8. Bit 31 reads back the valid flag. Bits 30:16 read as zero.
- R4: A high-word write sets the valid flag exactly when the stored low word or bits 15:0 of the written data are nonzero. Bit 31 of the written data is ignored.
- R5: A low-word write alone stores the new low word and leaves the valid flag unchanged.
- R6: `dst_addr[47:40]` is address byte 0 and `dst_addr[7:0]` is byte 5. A frame hits an entry when all six bytes equal that entry's stored bytes and the entry is valid.
- R7: An invalid entry never produces a hit, and this includes an all-zero destination address.
- R8: When several valid entries match, `match_idx` reports the lowest index.
- R9: `match_valid` is high exactly one cycle after each cycle in which `dst_valid` is high, including back-to-back frames. On a miss, `match_idx` is 0.
- R10: An initialise pulse loads `station_addr` into entry 0, using the same byte convention as `dst_addr`, and sets its valid flag only if that address is nonzero. It writes zero to all other entries and leaves them invalid. It takes precedence over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Entry index and half select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| init_pulse | input | 1 | Load station address and clear the table |
| station_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| match_valid | output | 1 | Result strobe, one cycle after dst_valid |
| match_hit | output | 1 | A valid entry matched |
| match_idx | output | IDX_W | Lowest matching entry index |

## Verification
The hardest state to reach from the ports is an entry whose valid flag no longer agrees with its contents. The stimulus builds one by rewriting only the low word of a valid entry. The following frames must then match the mixed address, and the flag must stay set. The bench also builds the reverse case: a high-word write with zero data and bit 31 forced high, on top of a zero low word, must leave the entry invalid. A separate case gives two entries the same address to exercise priority. Another places an initialise pulse in the same cycle as a register write to check that the pulse takes precedence.

// File: rtl/raf_pkg.sv
package raf_pkg;

  typedef struct packed {
    logic [15:0] hi;
    logic [31:0] lo;
  } raf_words_t;

  typedef struct packed {
    logic        vld;
    logic [15:0] hi;
    logic [31:0] lo;
  } raf_entry_t;

  // Wire-order address (byte 0 in the top bits) to stored little-endian words.
  function automatic raf_words_t raf_pack(input logic [47:0] mac);
    raf_words_t w;
    w.lo = {mac[23:16], mac[31:24], mac[39:32], mac[47:40]};
    w.hi = {mac[7:0], mac[15:8]};
    return w;
  endfunction

endpackage

// File: rtl/raf_rst_sync.sv
module raf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/raf_entry.sv
module raf_entry
  import raf_pkg::*;
#(
  parameter bit IS_BASE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  raf_words_t  station_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  raf_words_t  key_i,
  output raf_entry_t  entry_o,
  output logic        hit_o
);
  raf_entry_t cur_q, nxt;
  logic       en;

  always_comb begin
    nxt = cur_q;
    en  = 1'b0;
    if (init_i) begin
      en = 1'b1;
      if (IS_BASE) begin
        nxt.lo  = station_i.lo;
        nxt.hi  = station_i.hi;
        nxt.vld = |station_i;
      end else begin
        nxt = '0;
      end
    end else if (wr_hi_i) begin
      en      = 1'b1;
      nxt.hi  = wdata_i[15:0];
      nxt.vld = |{cur_q.lo, wdata_i[15:0]};
    end else if (wr_lo_i) begin
      en     = 1'b1;
      nxt.lo = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= '0;
    else if (en) cur_q <= nxt;
  end

  assign entry_o = cur_q;
  assign hit_o   = cur_q.vld && (cur_q.lo == key_i.lo) && (cur_q.hi == key_i.hi);
endmodule

// File: rtl/raf_prio_enc.sv
module raf_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             init_pulse,
  input  logic [47:0]      station_addr,
  input  logic             dst_valid,
  input  logic [47:0]      dst_addr,
  output logic             match_valid,
  output logic             match_hit,
  output logic [IDX_W-1:0] match_idx
);
  localparam int ADDR_W = IDX_W + 1;

  logic                   rst_sync_n;
  raf_words_t             key_w, station_w;
  raf_entry_t             ent [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit_vec, vld_vec, wr_lo, wr_hi;
  logic                   any_hit;
  logic [IDX_W-1:0]       hit_idx, rd_idx;
  logic                   rd_half;

  logic                   mv_q, mv_d, mh_q, mh_d;
  logic [IDX_W-1:0]       mi_q, mi_d;

  raf_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign key_w     = raf_pack(dst_addr);
  assign station_w = raf_pack(station_addr);
  assign rd_idx    = reg_addr[ADDR_W-1:1];
  assign rd_half   = reg_addr[0];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    assign wr_lo[g] = reg_wr && !rd_half && (rd_idx == IDX_W'(g));
    assign wr_hi[g] = reg_wr &&  rd_half && (rd_idx == IDX_W'(g));

    raf_entry #(.IS_BASE(g == 0)) u_entry (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .init_i   (init_pulse),
      .station_i(station_w),
      .wr_lo_i  (wr_lo[g]),
      .wr_hi_i  (wr_hi[g]),
      .wdata_i  (reg_wdata),
      .key_i    (key_w),
      .entry_o  (ent[g]),
      .hit_o    (hit_vec[g])
    );

    assign vld_vec[g] = ent[g].vld;
  end

  raf_prio_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req_i(hit_vec),
    .any_o(any_hit),
    .idx_o(hit_idx)
  );

  // Register read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        reg_rdata = rd_half ? {ent[i].vld, 15'd0, ent[i].hi} : ent[i].lo;
      end
    end
  end

  // Result stage: next state
  always_comb begin
    mv_d = dst_valid;
    mh_d = 1'b0;
    mi_d = '0;
    if (dst_valid && any_hit) begin
      mh_d = 1'b1;
      mi_d = hit_idx;
    end
  end

  // Result stage: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mv_q <= 1'b0;
      mh_q <= 1'b0;
      mi_q <= '0;
    end else begin
      mv_q <= mv_d;
      mh_q <= mh_d;
      mi_q <= mi_d;
    end
  end

  assign match_valid = mv_q;
  assign match_hit   = mh_q;
  assign match_idx   = mi_q;
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dst_valid,
  input logic             init_pulse,
  input logic [47:0]      station_addr,
  input logic             match_valid,
  input logic             match_hit,
  input logic [IDX_W-1:0] match_idx,
  input logic [N-1:0]     vld_vec,
  input logic [N-1:0]     hit_vec
);
  logic [N-1:0] prev_vld, prev_hit, below;
  logic         init_q, stn_nz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld <= '0;
      prev_hit <= '0;
      init_q   <= 1'b0;
      stn_nz_q <= 1'b0;
    end else begin
      prev_vld <= vld_vec;
      prev_hit <= hit_vec;
      init_q   <= init_pulse;
      stn_nz_q <= |station_addr;
    end
  end

  assign below = (N'(1) << match_idx) - N'(1);

  assert_result_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> match_valid);
  assert_no_spurious_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !match_valid);
  assert_miss_index_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !match_hit) |-> (match_idx == '0));
  assert_hit_only_when_strobed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> match_valid);
  assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> prev_vld[match_idx]);
  assert_lowest_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> ((prev_hit & below) == '0) && prev_hit[match_idx]);
  assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> (vld_vec[N-1:1] == '0) && (vld_vec[0] == stn_nz_q));
endmodule

bind rx_addr_filter raf_checker #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_raf_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .dst_valid   (dst_valid),
  .init_pulse  (init_pulse),
  .station_addr(station_addr),
  .match_valid (match_valid),
  .match_hit   (match_hit),
  .match_idx   (match_idx),
  .vld_vec     (vld_vec),
  .hit_vec     (hit_vec)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [IW:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          init_pulse = 1'b0;
  logic [47:0]   station_addr = '0;
  logic          dst_valid = 1'b0;
  logic [47:0]   dst_addr = '0;
  logic          match_valid, match_hit;
  logic [IW-1:0] match_idx;

  int checks = 0;
  int fails  = 0;
  logic mon_en = 1'b0;

  logic [31:0] m_lo [N];
  logic [15:0] m_hi [N];
  logic        m_v  [N];
  logic [IW:0] exp_q [$];

  always #2 clk = ~clk;

  rx_addr_filter #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_pulse(init_pulse),
    .station_addr(station_addr), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .match_valid(match_valid), .match_hit(match_hit), .match_idx(match_idx)
  );

  function automatic logic [7:0] byte_of(input logic [47:0] a, input int k);
    return a[(5 - k) * 8 +: 8];
  endfunction

  function automatic logic [31:0] lo_of(input logic [47:0] a);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = byte_of(a, k);
    return r;
  endfunction

  function automatic logic [15:0] hi_of(input logic [47:0] a);
    return {byte_of(a, 5), byte_of(a, 4)};
  endfunction

  function automatic logic [IW:0] lookup(input logic [47:0] a);
    for (int e = 0; e < N; e++)
      if (m_v[e] && m_lo[e] == lo_of(a) && m_hi[e] == hi_of(a))
        return {1'b1, IW'(e)};
    return '0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int e, input bit half, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {IW'(e), half}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (half) begin
      m_hi[e] = d[15:0];
      m_v[e]  = (m_lo[e] != 0) || (d[15:0] != 0);
    end else begin
      m_lo[e] = d;
    end
  endtask

  task automatic put_entry(input int e, input logic [47:0] a);
    reg_write(e, 1'b0, lo_of(a));
    reg_write(e, 1'b1, {16'hFFFF, hi_of(a)});
  endtask

  task automatic read_check(input string tag, input int e, input bit half, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = {IW'(e), half};
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(input logic [47:0] a);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    exp_q.push_back(lookup(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dst_valid = 1'b0;
    end
  endtask

  // Monitor: pops scoreboard on every result strobe (R9)
  always @(negedge clk) begin
    if (mon_en && match_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected result", 64'(1), 64'(0));
      else check("R6 R8 R9 result", 64'({match_hit, match_idx}), 64'(exp_q.pop_front()));
    end
  end

  logic [47:0] A = 48'h02_11_22_33_44_55;
  logic [47:0] B = 48'h0A_BC_DE_F0_12_34;
  logic [47:0] S = 48'h00_1B_21_AA_BB_CC;

  initial begin
    #400000;
    check("watchdog", 64'(0), 64'(1));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int e = 0; e < N; e++) begin m_lo[e] = '0; m_hi[e] = '0; m_v[e] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    // R1 reset state
    check("R1 match_valid", 64'(match_valid), 64'(0));
    for (int e = 0; e < N; e++) read_check("R1 high word", e, 1'b1, 32'h0);
    read_check("R1 low word", 5, 1'b0, 32'h0);

    // R2 R3 R4 layout and valid flag
    put_entry(3, A);
    read_check("R2 low layout", 3, 1'b0, 32'h33_22_11_02);
    read_check("R3 R4 high layout", 3, 1'b1, 32'h8000_5544);

    // R6 hit and miss, R9 miss index
    send(A); send(B); send(A); idle(3);

    // R4 R7 zero address with bit 31 forced stays invalid
    reg_write(5, 1'b0, 32'h0);
    reg_write(5, 1'b1, 32'h8000_0000);
    read_check("R4 zero stays invalid", 5, 1'b1, 32'h0);
    send(48'h0); idle(2);

    // R8 priority: same address in entries 7 and 2
    put_entry(7, B);
    send(B); idle(2);
    put_entry(2, B);
    send(B); idle(2);

    // R5 low write keeps valid, mixed address matches
    reg_write(3, 1'b0, lo_of(B));
    read_check("R5 valid kept", 3, 1'b1, 32'h8000_5544);
    send({B[47:16], A[15:0]}); send(A); idle(2);

    // R10 init overrides a same-cycle write
    @(negedge clk);
    station_addr = S; init_pulse = 1'b1;
    reg_wr = 1'b1; reg_addr = {IW'(4), 1'b1}; reg_wdata = 32'h0000_1234;
    @(negedge clk);
    init_pulse = 1'b0; reg_wr = 1'b0;
    for (int e = 0; e < N; e++) begin m_lo[e] = '0; m_hi[e] = '0; m_v[e] = 1'b0; end
    m_lo[0] = lo_of(S); m_hi[0] = hi_of(S); m_v[0] = 1'b1;
    read_check("R10 entry4 cleared", 4, 1'b1, 32'h0);
    read_check("R10 entry2 cleared", 2, 1'b0, 32'h0);
    read_check("R10 base low", 0, 1'b0, 32'hAA_21_1B_00);
    read_check("R10 base high", 0, 1'b1, 32'h8000_CCBB);
    send(S); send(B); send(A); send(S); idle(3);

    // R10 zero station leaves entry 0 invalid
    @(negedge clk);
    station_addr = 48'h0; init_pulse = 1'b1;
    @(negedge clk);
    init_pulse = 1'b0;
    m_lo[0] = '0; m_hi[0] = '0; m_v[0] = 1'b0;
    read_check("R10 zero station", 0, 1'b1, 32'h0);
    send(48'h0); send(S); idle(3);

    check("R9 scoreboard drained", 64'(exp_q.size()), 64'(0));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule